// File: doc/BRIEF.md
# Cascadable Product-Term Sum Cell

This block is the combinational logic slice of one cell in a sixteen-cell logic group. It forms five AND terms. Each term looks at a 56-bit input vector: 40 signals picked by the group's routing and 16 signals from the group's shared feedback bus. An allocation stage sends each term either into the cell's OR gate or out as a control term for the storage element, which lies outside this block.

The OR gate also takes a chain input from the neighbouring cell. The cell passes its complete sum on as its own chain output, so eight linked cells can build a sum of forty terms. A final XOR sets the output polarity. Its second operand is a fixed 0, a fixed 1, or one of the cell's own terms. The cell also drives one bit back onto the shared feedback bus, and that bit is the inverse of a chosen term.

All AND masks and selections come from a configuration register. The configuration is shifted in serially and becomes active only when a load strobe is given.

Top module: `ptsum_cell`

## Requirements
- R1: Input bit i of the term vector is `sel_in[i]` for i < 40 and `reg_bus[i-40]` for i >= 40. A term is the AND of every enabled true literal (input must be 1) and every enabled complement literal (input must be 0). A term with no literal enabled is 1.
- R2: When the kill bit of a term is set, that term is 0 whatever its inputs are.
- R3: When the route bit of term k is 1, the term feeds the OR gate and `ctl_terms[k]` is 0. When the route bit is 0, `ctl_terms[k]` equals the term and the term is kept out of the OR gate.
- R4: `casc_out` is the OR of every routed term together with `casc_in`. A high `casc_in` therefore forces `casc_out` high.
- R5: `sum_out` is `casc_out` XOR an operand chosen by the polarity mode. Mode 0 gives 0 and mode 1 gives 1. Mode 2 or 3 gives term[xor_sel], or 0 when xor_sel is 5 or more.
- R6: `fold_out` is the inverse of term[fold_sel]. When fold_sel is 5 or more, `fold_out` is 1.
- R7: While `cfg_shift` is high, each clock edge moves the staging register one place toward its top bit and puts `cfg_sin` into bit 0. Shifting alone never changes the outputs. A clock edge with `cfg_load` high copies the staging value, as it stood before that edge, into the active configuration.
- R8: The active configuration bit layout is fixed. Term k uses the 114 bits starting at bit 114*k: true mask [55:0], complement mask [111:56], kill at bit 112 and route at bit 113. The polarity mode sits at [571:570], xor_sel at [574:572] and fold_sel at [577:575].
- R9: Reset clears both the staging and the active configuration. After reset every term is 1, `ctl_terms` is all ones, `sum_out` equals `casc_in` and `fold_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sin | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift enable for the staging register |
| cfg_load | input | 1 | Copy staging to active configuration |
| sel_in | input | 40 | Routed input signals |
| reg_bus | input | 16 | Shared group feedback bus |
| casc_in | input | 1 | Chain sum from the neighbouring cell |
| sum_out | output | 1 | Polarity-adjusted sum |
| casc_out | output | 1 | Chain sum to the next cell |
| fold_out | output | 1 | Inverted term driven back onto the feedback bus |
| ctl_terms | output | 5 | Terms allocated to control use |

## Verification
The bench aims at the places where a cell usually goes wrong. A term with empty masks must read 1; a design that ANDs from 0 would make it 0 and drop every constant-true control term. A killed term with empty masks must not leak into the sum, or the sum would stick at 1. A high chain input must win over an empty local sum, or long chains would lose terms. Out-of-range polarity and fold selections must give 0 and 1, or the outputs would follow a stray term. The bench also changes the inputs while a new configuration is shifted in without a load, and then does a shift and a load in the same cycle. A design that reads the staging register directly, or loads the value after that cycle's shift, would differ from the model on those cycles.

// File: rtl/ptsum_pkg.sv
package ptsum_pkg;
  typedef enum logic [1:0] {
    XM_ZERO = 2'd0,
    XM_ONE  = 2'd1,
    XM_TERM = 2'd2,
    XM_ALT  = 2'd3
  } xor_mode_e;

  function automatic int unsigned sel_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ptsum_cfg_reg.sv
module ptsum_cfg_reg #(
  parameter int unsigned W = 578
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sin,
  input  logic         shift_en,
  input  logic         load_en,
  output logic [W-1:0] active_o
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] act_q, act_d;

  always_comb begin
    stage_d = stage_q;
    act_d   = act_q;
    if (shift_en) stage_d = {stage_q[W-2:0], sin};
    if (load_en)  act_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign active_o = act_q;

  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(act_q));
  a_r7_load_takes_stage: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> act_q == $past(stage_q));
endmodule

// File: rtl/ptsum_term.sv
module ptsum_term #(
  parameter int unsigned N_IN = 56
) (
  input  logic [N_IN-1:0] x,
  input  logic [N_IN-1:0] true_en,
  input  logic [N_IN-1:0] comp_en,
  input  logic            kill,
  output logic            term
);
  logic [N_IN-1:0] lit_ok;

  always_comb begin
    lit_ok = (~true_en | x) & (~comp_en | ~x);
    term   = ~kill & (&lit_ok);
  end
endmodule

// File: rtl/ptsum_combine.sv
module ptsum_combine
  import ptsum_pkg::*;
#(
  parameter int unsigned N_PT  = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_PT-1:0]  pt,
  input  logic [N_PT-1:0]  route,
  input  logic             casc_in,
  input  xor_mode_e        xmode,
  input  logic [SEL_W-1:0] xsel,
  input  logic [SEL_W-1:0] fsel,
  output logic             sum_out,
  output logic             casc_out,
  output logic             fold_out,
  output logic [N_PT-1:0]  ctl_terms
);
  logic or_sum;
  logic xop;
  logic picked;

  always_comb begin
    or_sum    = (|(pt & route)) | casc_in;
    ctl_terms = pt & ~route;

    picked = 1'b0;
    for (int k = 0; k < int'(N_PT); k++) begin
      if (xsel == SEL_W'(k)) picked = pt[k];
    end
    unique case (xmode)
      XM_ZERO: xop = 1'b0;
      XM_ONE:  xop = 1'b1;
      default: xop = picked;
    endcase

    fold_out = 1'b1;
    for (int k = 0; k < int'(N_PT); k++) begin
      if (fsel == SEL_W'(k)) fold_out = ~pt[k];
    end

    casc_out = or_sum;
    sum_out  = or_sum ^ xop;
  end
endmodule

// File: rtl/ptsum_cell.sv
module ptsum_cell
  import ptsum_pkg::*;
#(
  parameter int unsigned N_SEL = 40,
  parameter int unsigned N_REG = 16,
  parameter int unsigned N_PT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sin,
  input  logic             cfg_shift,
  input  logic             cfg_load,
  input  logic [N_SEL-1:0] sel_in,
  input  logic [N_REG-1:0] reg_bus,
  input  logic             casc_in,
  output logic             sum_out,
  output logic             casc_out,
  output logic             fold_out,
  output logic [N_PT-1:0]  ctl_terms
);
  localparam int unsigned N_IN  = N_SEL + N_REG;
  localparam int unsigned PT_W  = 2 * N_IN + 2;
  localparam int unsigned SEL_W = sel_bits(N_PT);
  localparam int unsigned TAIL  = N_PT * PT_W;
  localparam int unsigned CFG_W = TAIL + 2 + 2 * SEL_W;

  logic [CFG_W-1:0] cfg;
  logic [N_IN-1:0]  xin;
  logic [N_PT-1:0]  pt, route, kill;
  xor_mode_e        xmode;
  logic [SEL_W-1:0] xsel, fsel;

  assign xin   = {reg_bus, sel_in};
  assign xmode = xor_mode_e'(cfg[TAIL +: 2]);
  assign xsel  = cfg[TAIL+2 +: SEL_W];
  assign fsel  = cfg[TAIL+2+SEL_W +: SEL_W];

  ptsum_cfg_reg #(.W(CFG_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sin      (cfg_sin),
    .shift_en (cfg_shift),
    .load_en  (cfg_load),
    .active_o (cfg)
  );

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    assign kill[k]  = cfg[k*PT_W + 2*N_IN];
    assign route[k] = cfg[k*PT_W + 2*N_IN + 1];
    ptsum_term #(.N_IN(N_IN)) term_i (
      .x       (xin),
      .true_en (cfg[k*PT_W +: N_IN]),
      .comp_en (cfg[k*PT_W + N_IN +: N_IN]),
      .kill    (kill[k]),
      .term    (pt[k])
    );
    // R2: a killed term never reaches the OR gate or a control output
    a_r2_kill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      kill[k] |-> !ctl_terms[k]);
  end

  ptsum_combine #(.N_PT(N_PT), .SEL_W(SEL_W)) comb_i (
    .pt        (pt),
    .route     (route),
    .casc_in   (casc_in),
    .xmode     (xmode),
    .xsel      (xsel),
    .fsel      (fsel),
    .sum_out   (sum_out),
    .casc_out  (casc_out),
    .fold_out  (fold_out),
    .ctl_terms (ctl_terms)
  );

  a_r3_ctl_excludes_routed: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_terms & route) == '0);
  a_r4_chain_forces_sum: assert property (@(posedge clk) disable iff (!rst_n)
    casc_in |-> casc_out);
  a_r5_const_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (xmode == XM_ONE) |-> (sum_out != casc_out));
  a_r6_fold_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fsel} >= (SEL_W+1)'(N_PT)) |-> fold_out);
endmodule

// File: tb/ptsum_cell_tb.sv
module ptsum_cell_tb_top;
  localparam int N_SEL = 40;
  localparam int N_REG = 16;
  localparam int N_PT  = 5;
  localparam int N_IN  = N_SEL + N_REG;
  localparam int PT_W  = 2 * N_IN + 2;
  localparam int TAIL  = N_PT * PT_W;
  localparam int CFG_W = TAIL + 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_sin, cfg_shift, cfg_load;
  logic [N_SEL-1:0] sel_in;
  logic [N_REG-1:0] reg_bus;
  logic casc_in;
  logic sum_out, casc_out, fold_out;
  logic [N_PT-1:0] ctl_terms;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [CFG_W-1:0] m_stage, m_act, cfg_v;

  always #5 clk = ~clk;

  ptsum_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sin(cfg_sin), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .sel_in(sel_in), .reg_bus(reg_bus), .casc_in(casc_in),
    .sum_out(sum_out), .casc_out(casc_out), .fold_out(fold_out), .ctl_terms(ctl_terms)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: configuration registers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage <= '0;
      m_act   <= '0;
    end else begin
      if (cfg_load)  m_act   <= m_stage;
      if (cfg_shift) m_stage <= {m_stage[CFG_W-2:0], cfg_sin};
    end
  end

  task automatic model(output logic e_sum, output logic e_casc, output logic e_fold,
                       output logic [N_PT-1:0] e_ctl);
    logic [N_IN-1:0] x;
    logic [N_PT-1:0] t;
    logic orv, xo;
    int mode, xs, fs;
    x = {reg_bus, sel_in};
    for (int k = 0; k < N_PT; k++) begin
      t[k] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (m_act[k*PT_W + i] == 1'b1 && x[i] == 1'b0) t[k] = 1'b0;
        if (m_act[k*PT_W + N_IN + i] == 1'b1 && x[i] == 1'b1) t[k] = 1'b0;
      end
      if (m_act[k*PT_W + 2*N_IN]) t[k] = 1'b0;
    end
    orv = casc_in;
    e_ctl = '0;
    for (int k = 0; k < N_PT; k++) begin
      if (m_act[k*PT_W + 2*N_IN + 1]) orv = orv | t[k];
      else e_ctl[k] = t[k];
    end
    mode = int'(m_act[TAIL +: 2]);
    xs   = int'(m_act[TAIL+2 +: 3]);
    fs   = int'(m_act[TAIL+5 +: 3]);
    if (mode == 0) xo = 1'b0;
    else if (mode == 1) xo = 1'b1;
    else xo = (xs < N_PT) ? t[xs] : 1'b0;
    e_casc = orv;
    e_sum  = orv ^ xo;
    e_fold = (fs < N_PT) ? ~t[fs] : 1'b1;
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic es, ec, ef;
      logic [N_PT-1:0] ek;
      model(es, ec, ef, ek);
      chk("R5 sum_out vs model", 32'(sum_out), 32'(es));
      chk("R4 casc_out vs model", 32'(casc_out), 32'(ec));
      chk("R6 fold_out vs model", 32'(fold_out), 32'(ef));
      chk("R3 ctl_terms vs model", 32'(ctl_terms), 32'(ek));
    end
  end

  task automatic put_term(input int k, input logic [N_IN-1:0] tm, input logic [N_IN-1:0] cm,
                          input logic kill, input logic route);
    cfg_v[k*PT_W +: N_IN]        = tm;
    cfg_v[k*PT_W + N_IN +: N_IN] = cm;
    cfg_v[k*PT_W + 2*N_IN]       = kill;
    cfg_v[k*PT_W + 2*N_IN + 1]   = route;
  endtask

  task automatic put_tail(input logic [1:0] mode, input logic [2:0] xs, input logic [2:0] fs);
    cfg_v[TAIL +: 2]   = mode;
    cfg_v[TAIL+2 +: 3] = xs;
    cfg_v[TAIL+5 +: 3] = fs;
  endtask

  // R7: shift MSB first; inputs toggle while shifting
  task automatic shift_cfg(input bit rand_in);
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_sin   = cfg_v[i];
      cfg_shift = 1'b1;
      if (rand_in) begin
        sel_in  = {$urandom, $urandom};
        reg_bus = 16'($urandom);
        casc_in = 1'($urandom);
      end
      @(posedge clk); #1;
    end
    cfg_shift = 1'b0;
  endtask

  task automatic load_cfg();
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic apply(input logic [N_SEL-1:0] s, input logic [N_REG-1:0] r, input logic c);
    sel_in = s; reg_bus = r; casc_in = c;
    @(negedge clk);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      sel_in  = {$urandom, $urandom};
      reg_bus = 16'($urandom);
      casc_in = 1'($urandom);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic held;
    rst_n = 1'b0; cfg_sin = 0; cfg_shift = 0; cfg_load = 0;
    sel_in = '0; reg_bus = '0; casc_in = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R9: reset state
    apply('0, '0, 1'b0);
    chk("R9 reset ctl all ones", 32'(ctl_terms), 32'h1f);
    chk("R9 reset sum follows chain in", 32'(sum_out), 32'd0);
    chk("R9 reset fold low", 32'(fold_out), 32'd0);
    apply('0, '0, 1'b1);
    chk("R9 reset sum with chain in high", 32'(sum_out), 32'd1);

    // configuration A (R8 layout)
    cfg_v = '0;
    put_term(0, 56'h1, 56'h1 << 41, 1'b0, 1'b1);   // x0 & ~x41
    put_term(1, '0, '0, 1'b1, 1'b1);               // killed, empty masks
    put_term(2, 56'h1 << 39, '0, 1'b0, 1'b1);      // x39
    put_term(3, '0, 56'h1 << 5, 1'b0, 1'b0);       // ~x5, control
    put_term(4, '0, '0, 1'b0, 1'b0);               // empty, control
    put_tail(2'd0, 3'd0, 3'd0);
    shift_cfg(1'b1);
    load_cfg();

    apply('0, '0, 1'b0);
    chk("R2 killed empty term stays out of sum", 32'(sum_out), 32'd0);
    chk("R1 empty term reads one on ctl", 32'(ctl_terms), 32'h18);
    chk("R6 fold of term0 low is high", 32'(fold_out), 32'd1);
    apply(40'h1, '0, 1'b0);
    chk("R1 true literal x0 with ~x41 met", 32'(sum_out), 32'd1);
    apply(40'h1, 16'h2, 1'b0);
    chk("R1 complement literal on reg_bus bit 1", 32'(sum_out), 32'd0);
    apply(40'h20, '0, 1'b0);
    chk("R3 control term drops when x5 high", 32'(ctl_terms), 32'h10);
    apply('0, '0, 1'b1);
    chk("R4 chain in forces chain out", 32'(casc_out), 32'd1);
    random_run(60);

    // configuration B: polarity invert; shift without load first
    apply('0, '0, 1'b0);
    held = sum_out;
    cfg_v = '0;
    put_term(0, 56'h1, '0, 1'b0, 1'b1);
    put_term(1, 56'h2, 56'h4, 1'b0, 1'b0);
    put_term(2, 56'h8, 56'h8, 1'b0, 1'b1);         // contradictory: always 0
    put_term(3, '0, '0, 1'b0, 1'b0);
    put_term(4, 56'hff << 40, '0, 1'b0, 1'b1);
    put_tail(2'd1, 3'd0, 3'd3);
    shift_cfg(1'b1);
    apply('0, '0, 1'b0);
    chk("R7 shift alone leaves outputs", 32'(sum_out), 32'(held));
    load_cfg();
    apply('0, '0, 1'b0);
    chk("R5 constant one inverts empty sum", 32'(sum_out), 32'd1);
    chk("R6 fold of empty term3", 32'(fold_out), 32'd0);
    apply(40'h8, '0, 1'b0);
    chk("R1 true and complement on one input", 32'(casc_out), 32'd0);
    random_run(60);

    // configuration C: XOR with term4, fold select out of range
    cfg_v = '0;
    put_term(0, 56'h10, '0, 1'b0, 1'b1);
    put_term(4, 56'h3 << 40, '0, 1'b0, 1'b0);
    put_tail(2'd2, 3'd4, 3'd6);
    shift_cfg(1'b0);
    load_cfg();
    apply(40'h10, 16'h3, 1'b0);
    chk("R5 xor with term4 high", 32'(sum_out), 32'd0);
    chk("R6 fold select out of range", 32'(fold_out), 32'd1);
    apply(40'h10, 16'h1, 1'b0);
    chk("R5 xor with term4 low", 32'(sum_out), 32'd1);
    random_run(60);

    // configuration D: mode 3, xor select out of range; shift and load same cycle
    cfg_v = '0;
    put_term(1, '0, '0, 1'b0, 1'b1);
    put_tail(2'd3, 3'd7, 3'd1);
    shift_cfg(1'b0);
    cfg_sin = 1'b1; cfg_shift = 1'b1; cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_shift = 1'b0; cfg_load = 1'b0;
    apply('0, '0, 1'b0);
    chk("R7 load takes stage before shift", 32'(sum_out), 32'd1);
    chk("R5 xor select out of range is zero", 32'(casc_out), 32'd1);
    chk("R6 fold of constant term", 32'(fold_out), 32'd0);
    random_run(40);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule